// File: doc/BRIEF.md
# Application-Aware Memory Protection Unit

This block sits between the processor and its program and data memories and decides, for every instruction fetch and every data load or store, whether the address belongs to the application that is running now. An application tracker outside the block supplies the running application's ID. For each of up to eight application IDs the block holds a program window and a data window, each given as an inclusive lower bound and an exclusive upper bound. It also holds one protected window that covers the trusted domain's private data and stack. No application may read or write inside that window, even where its own data window overlaps it.

The trusted domain runs under a reserved ID. That ID bypasses every window check, and only that ID may load bounds. A denied access never reaches memory: the write strobe stays low and the read data returned to the core is forced to zero. One cycle after the decision, the block raises a single-cycle violation pulse for the panic logic. A data access that uses direct addressing spends one stall cycle while its window comparison is registered. An indirect data access, or a fetch, is decided in the same cycle.

Top module: `app_mpu`

## Requirements
- R1: A fetch (access kind code 0) by application ID 0..7 is granted only when program-lower <= address < program-upper for that ID. Otherwise it is denied.
- R2: A read (kind code 1) or write (kind code 2) by ID 0..7 is granted only when data-lower <= address < data-upper for that ID and the address lies outside the protected window, protected-lower <= address < protected-upper.
- R3: A window whose lower bound is equal to or above its upper bound grants no address.
- R4: ID 8 (the trusted domain) is granted every access of kind 0..2 whatever the bounds are. IDs 9..15 are denied every access.
- R5: A bound write (cfg_we) takes effect only while app_id is 8. Field codes: 0 program-lower, 1 program-upper, 2 data-lower, 3 data-upper, 4 protected-lower, 5 protected-upper. Codes 4 and 5 ignore cfg_app. Writes with codes 6 and 7, writes to cfg_app 8..15 with codes 0..3, and writes while app_id is not 8 change nothing.
- R6: A read or write with acc_direct high stalls for exactly one cycle (acc_stall high, acc_grant low) and is decided in the next cycle, provided the core holds the inputs. Fetches and indirect accesses are decided in the cycle they are presented, with no stall.
- R7: A denied decision raises violation for one cycle, in the cycle after the decision cycle. A granted decision raises no violation.
- R8: mem_we is high only during a granted write. acc_rdata equals mem_rdata during a granted read and is zero at all other times.
- R9: After reset every bound is zero, so every application ID 0..7 is denied, and acc_grant, acc_stall, mem_we and violation are low.
- R10: Access kind code 3 is reserved and is denied for every ID, including the trusted domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| app_id | input | 4 | Running application ID from the tracker (8 = trusted domain) |
| cfg_we | input | 1 | Bound write strobe |
| cfg_app | input | 4 | Application whose bound is written |
| cfg_field | input | 3 | Bound selector (codes in R5) |
| cfg_data | input | 16 | Bound value |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| acc_direct | input | 1 | Data access uses direct addressing |
| acc_addr | input | 16 | Access address |
| mem_rdata | input | 16 | Read data from memory |
| acc_grant | output | 1 | Access allowed in this decision cycle |
| acc_stall | output | 1 | Validation wait cycle for a direct data access |
| mem_we | output | 1 | Gated write strobe to memory |
| acc_rdata | output | 16 | Read data returned to the core, zero unless granted |
| violation | output | 1 | One-cycle pulse to the panic logic |

## Verification
The embedded assertions check on every cycle that a stall never lasts two cycles and never comes with a grant, and that fetches never stall. They also check that every violation pulse follows a denied decision, that the write strobe and read data leak only on a granted access, that IDs above the trusted one are never granted, and that a bound write attempted outside trusted mode leaves every bound unchanged. The actual window arithmetic only shows up in the bench's scenarios: the exact inclusive and exclusive edges, empty windows, the protected window carved out of an application's data window, and the trusted bypass. The bench compares each decision against a model of the bounds it has loaded, using random windows, addresses clustered on the edges, and a set of directed cases.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLD_PROG_LO = 3'd0,
    FLD_PROG_HI = 3'd1,
    FLD_DATA_LO = 3'd2,
    FLD_DATA_HI = 3'd3,
    FLD_PROT_LO = 3'd4,
    FLD_PROT_HI = 3'd5
  } bnd_field_e;

endpackage

// File: rtl/mpu_range_chk.sv
// Half-open window test: lo <= addr < hi. An empty window (lo >= hi) never hits.
module mpu_range_chk #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              hit
);
  always_comb begin
    hit = (addr >= lo) && (addr < hi);
  end
endmodule

// File: rtl/mpu_bound_regs.sv
// Per-application bound storage plus the protected window; writable only when allowed.
module mpu_bound_regs
  import mpu_pkg::*;
#(
  parameter int NUM_APPS = 8,
  parameter int ADDR_W   = 16,
  parameter int ID_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_allow,
  input  logic [ID_W-1:0]   wr_app,
  input  logic [2:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ID_W-1:0]   rd_app,
  output logic [ADDR_W-1:0] prog_lo,
  output logic [ADDR_W-1:0] prog_hi,
  output logic [ADDR_W-1:0] data_lo,
  output logic [ADDR_W-1:0] data_hi,
  output logic [ADDR_W-1:0] prot_lo,
  output logic [ADDR_W-1:0] prot_hi
);
  localparam int IDX_W = $clog2(NUM_APPS);

  logic [NUM_APPS-1:0][3:0][ADDR_W-1:0] app_q, app_d;
  logic [1:0][ADDR_W-1:0]               prot_q, prot_d;
  logic                                 wr_ok;
  logic                                 wr_app_ok;
  logic                                 rd_app_ok;

  always_comb begin
    wr_ok     = wr_req && wr_allow;
    wr_app_ok = (wr_app < ID_W'(NUM_APPS));
    rd_app_ok = (rd_app < ID_W'(NUM_APPS));
  end

  for (genvar g = 0; g < NUM_APPS; g++) begin : g_app
    always_comb begin
      app_d[g] = app_q[g];
      if (wr_ok && wr_app_ok && (wr_app[IDX_W-1:0] == IDX_W'(g)) && (wr_field < 3'd4))
        app_d[g][wr_field[1:0]] = wr_data;
    end
  end

  always_comb begin
    prot_d = prot_q;
    if (wr_ok && (wr_field == FLD_PROT_LO)) prot_d[0] = wr_data;
    if (wr_ok && (wr_field == FLD_PROT_HI)) prot_d[1] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_q  <= '0;
      prot_q <= '0;
    end else if (wr_ok) begin
      app_q  <= app_d;
      prot_q <= prot_d;
    end
  end

  always_comb begin
    if (rd_app_ok) begin
      prog_lo = app_q[rd_app[IDX_W-1:0]][0];
      prog_hi = app_q[rd_app[IDX_W-1:0]][1];
      data_lo = app_q[rd_app[IDX_W-1:0]][2];
      data_hi = app_q[rd_app[IDX_W-1:0]][3];
    end else begin
      prog_lo = '0;
      prog_hi = '0;
      data_lo = '0;
      data_hi = '0;
    end
    prot_lo = prot_q[0];
    prot_hi = prot_q[1];
  end

  // R5: a write attempted outside trusted mode leaves all bounds untouched
  assert_locked_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_allow) |=> ($stable(app_q) && $stable(prot_q)));

endmodule

// File: rtl/app_mpu.sv
module app_mpu
  import mpu_pkg::*;
#(
  parameter int NUM_APPS = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int ID_W     = $clog2(NUM_APPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   app_id,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_app,
  input  logic [2:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic              acc_direct,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              acc_grant,
  output logic              acc_stall,
  output logic              mem_we,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              violation
);
  localparam logic [ID_W-1:0] TD_ID = ID_W'(NUM_APPS);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  acc_kind_e         kind;
  logic              is_td, id_ok, is_data;
  logic [ADDR_W-1:0] plo, phi, dlo, dhi, tlo, thi;
  logic              hit_prog, hit_data, hit_prot;
  logic              ok_now, ok_eff, need_wait, decide;
  logic              wait_q, wait_d, ok_q, ok_d, viol_q, viol_d;

  always_comb begin
    kind    = acc_kind_e'(acc_kind);
    is_td   = (app_id == TD_ID);
    id_ok   = (app_id < TD_ID);
    is_data = (kind == ACC_READ) || (kind == ACC_WRITE);
  end

  mpu_bound_regs #(.NUM_APPS(NUM_APPS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_req(cfg_we), .wr_allow(is_td), .wr_app(cfg_app),
    .wr_field(cfg_field), .wr_data(cfg_data), .rd_app(app_id),
    .prog_lo(plo), .prog_hi(phi), .data_lo(dlo), .data_hi(dhi),
    .prot_lo(tlo), .prot_hi(thi)
  );

  mpu_range_chk #(.ADDR_W(ADDR_W)) u_prog (.addr(acc_addr), .lo(plo), .hi(phi), .hit(hit_prog));
  mpu_range_chk #(.ADDR_W(ADDR_W)) u_data (.addr(acc_addr), .lo(dlo), .hi(dhi), .hit(hit_data));
  mpu_range_chk #(.ADDR_W(ADDR_W)) u_prot (.addr(acc_addr), .lo(tlo), .hi(thi), .hit(hit_prot));

  // decision and next state
  always_comb begin
    unique case (kind)
      ACC_FETCH:          ok_now = is_td || (id_ok && hit_prog);
      ACC_READ, ACC_WRITE: ok_now = is_td || (id_ok && hit_data && !hit_prot);
      default:            ok_now = 1'b0;
    endcase
    need_wait = acc_valid && acc_direct && is_data && !wait_q;
    decide    = acc_valid && !need_wait;
    ok_eff    = wait_q ? ok_q : ok_now;
    wait_d    = need_wait;
    ok_d      = need_wait ? ok_now : ok_q;
    viol_d    = decide && !ok_eff;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wait_q <= 1'b0;
      ok_q   <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
      ok_q   <= ok_d;
      viol_q <= viol_d;
    end
  end

  always_comb begin
    acc_grant = decide && ok_eff;
    acc_stall = need_wait;
    mem_we    = acc_grant && (kind == ACC_WRITE);
    acc_rdata = (acc_grant && (kind == ACC_READ)) ? mem_rdata : '0;
    violation = viol_q;
  end

  assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_stall |=> !acc_stall);
  assert_stall_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_stall |-> !acc_grant);
  assert_fetch_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_kind == 2'd0) |-> !acc_stall);
  assert_viol_after_deny_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    violation |-> $past(acc_valid && !acc_stall && !acc_grant));
  assert_we_granted_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> (acc_grant && acc_kind == 2'd2));
  assert_rdata_gated_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(acc_grant && acc_kind == 2'd1) |-> (acc_rdata == '0));
  assert_bad_id_denied_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (app_id > TD_ID) |-> !acc_grant);

endmodule

// File: tb/tb_app_mpu.sv
`timescale 1ns/1ps
module tb_app_mpu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  app_id;
  logic        cfg_we;
  logic [3:0]  cfg_app;
  logic [2:0]  cfg_field;
  logic [15:0] cfg_data;
  logic        acc_valid;
  logic [1:0]  acc_kind;
  logic        acc_direct;
  logic [15:0] acc_addr;
  logic [15:0] mem_rdata;
  logic        acc_grant, acc_stall, mem_we, violation;
  logic [15:0] acc_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [15:0] m_b[8][4];
  logic [15:0] m_tlo, m_thi;

  always #4 clk = ~clk;

  app_mpu dut (
    .clk(clk), .rst_n(rst_n), .app_id(app_id), .cfg_we(cfg_we), .cfg_app(cfg_app),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_direct(acc_direct), .acc_addr(acc_addr),
    .mem_rdata(mem_rdata), .acc_grant(acc_grant), .acc_stall(acc_stall),
    .mem_we(mem_we), .acc_rdata(acc_rdata), .violation(violation)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a, input logic [15:0] lo, input logic [15:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  function automatic bit exp_ok(input logic [3:0] id, input logic [1:0] k, input logic [15:0] a);
    if (k == 2'd3) return 1'b0;
    if (id == 4'd8) return 1'b1;
    if (id > 4'd8) return 1'b0;
    if (k == 2'd0) return in_win(a, m_b[id[2:0]][0], m_b[id[2:0]][1]);
    return in_win(a, m_b[id[2:0]][2], m_b[id[2:0]][3]) && !in_win(a, m_tlo, m_thi);
  endfunction

  task automatic cfg_wr(input logic [3:0] who, input logic [3:0] app, input logic [2:0] fld,
                        input logic [15:0] val);
    @(negedge clk);
    app_id = who; cfg_we = 1'b1; cfg_app = app; cfg_field = fld; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (who == 4'd8) begin
      if (fld == 3'd4) m_tlo = val;
      else if (fld == 3'd5) m_thi = val;
      else if (fld < 3'd4 && app < 4'd8) m_b[app[2:0]][fld[1:0]] = val;
    end
  endtask

  task automatic access(input string req, input logic [3:0] id, input logic [1:0] k,
                        input bit direct, input logic [15:0] a);
    bit ok;
    ok = exp_ok(id, k, a);
    @(negedge clk);
    app_id = id; acc_kind = k; acc_direct = direct; acc_addr = a; acc_valid = 1'b1;
    mem_rdata = 16'hA5C3 ^ a;
    #1;
    if (direct && (k == 2'd1 || k == 2'd2)) begin
      chk({req, " R6 stall"}, int'(acc_stall), 1);
      chk({req, " R6 no grant while stalled"}, int'(acc_grant), 0);
      @(negedge clk);
      #1;
    end
    chk({req, " R6 decision without stall"}, int'(acc_stall), 0);
    chk({req, " grant"}, int'(acc_grant), int'(ok));
    chk({req, " R8 mem_we"}, int'(mem_we), int'(ok && k == 2'd2));
    chk({req, " R8 rdata"}, int'(acc_rdata), (ok && k == 2'd1) ? int'(16'hA5C3 ^ a) : 0);
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    chk({req, " R7 violation pulse"}, int'(violation), int'(!ok));
    @(negedge clk);
    #1;
    chk({req, " R7 pulse ends"}, int'(violation), 0);
  endtask

  function automatic logic [15:0] pick_addr(input logic [3:0] id);
    int s;
    logic [2:0] i;
    i = id[2:0];
    s = int'($urandom_range(0, 9));
    case (s)
      0: return m_b[i][0];
      1: return m_b[i][1];
      2: return m_b[i][1] - 16'd1;
      3: return m_b[i][2];
      4: return m_b[i][3];
      5: return m_b[i][3] - 16'd1;
      6: return m_tlo;
      7: return m_thi - 16'd1;
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; app_id = 4'd0; cfg_we = 1'b0; cfg_app = 4'd0; cfg_field = 3'd0;
    cfg_data = 16'd0; acc_valid = 1'b0; acc_kind = 2'd0; acc_direct = 1'b0;
    acc_addr = 16'd0; mem_rdata = 16'd0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 4; j++) m_b[i][j] = 16'd0;
    m_tlo = 16'd0; m_thi = 16'd0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 grant in reset", int'(acc_grant), 0);
    chk("R9 violation in reset", int'(violation), 0);
    chk("R9 mem_we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R9 stall after reset", int'(acc_stall), 0);
    access("R9 zero bounds deny fetch", 4'd0, 2'd0, 1'b0, 16'h0000);
    access("R9 zero bounds deny read", 4'd3, 2'd1, 1'b0, 16'h0000);

    // directed windows for application 2
    cfg_wr(4'd8, 4'd2, 3'd0, 16'h0100);
    cfg_wr(4'd8, 4'd2, 3'd1, 16'h0200);
    cfg_wr(4'd8, 4'd2, 3'd2, 16'h1000);
    cfg_wr(4'd8, 4'd2, 3'd3, 16'h2000);
    cfg_wr(4'd8, 4'd0, 3'd4, 16'h1800);
    cfg_wr(4'd8, 4'd0, 3'd5, 16'h1900);
    access("R1 fetch at lower bound", 4'd2, 2'd0, 1'b0, 16'h0100);
    access("R1 fetch at upper-1", 4'd2, 2'd0, 1'b0, 16'h01FF);
    access("R1 fetch at upper", 4'd2, 2'd0, 1'b0, 16'h0200);
    access("R1 fetch below lower", 4'd2, 2'd0, 1'b0, 16'h00FF);
    access("R1 fetch by other app", 4'd1, 2'd0, 1'b0, 16'h0100);
    access("R2 indirect read in data", 4'd2, 2'd1, 1'b0, 16'h1000);
    access("R6 direct write in data", 4'd2, 2'd2, 1'b1, 16'h1FFF);
    access("R2 read in protected window", 4'd2, 2'd1, 1'b0, 16'h1800);
    access("R2 write at protected upper", 4'd2, 2'd2, 1'b1, 16'h1900);
    access("R8 direct write beyond data", 4'd2, 2'd2, 1'b1, 16'h2000);
    access("R2 read of program space", 4'd2, 2'd1, 1'b0, 16'h0100);
    access("R4 trusted fetch anywhere", 4'd8, 2'd0, 1'b0, 16'h9999);
    access("R4 trusted read protected", 4'd8, 2'd1, 1'b1, 16'h1850);
    access("R4 id 9 denied", 4'd9, 2'd1, 1'b0, 16'h1000);
    access("R4 id 15 denied", 4'd15, 2'd0, 1'b0, 16'h0100);
    access("R10 reserved kind app", 4'd2, 2'd3, 1'b0, 16'h1000);
    access("R10 reserved kind trusted", 4'd8, 2'd3, 1'b0, 16'h1000);
    // R5: untrusted attempt to move a bound is dropped
    cfg_wr(4'd2, 4'd2, 3'd0, 16'h0300);
    access("R5 bound unchanged after app write", 4'd2, 2'd0, 1'b0, 16'h0100);
    cfg_wr(4'd8, 4'd2, 3'd6, 16'h0000);
    access("R5 unused field code ignored", 4'd2, 2'd0, 1'b0, 16'h0150);
    // R3 empty and inverted windows
    cfg_wr(4'd8, 4'd5, 3'd0, 16'h0040);
    cfg_wr(4'd8, 4'd5, 3'd1, 16'h0040);
    access("R3 empty window", 4'd5, 2'd0, 1'b0, 16'h0040);
    cfg_wr(4'd8, 4'd5, 3'd2, 16'h0800);
    cfg_wr(4'd8, 4'd5, 3'd3, 16'h0400);
    access("R3 inverted window", 4'd5, 2'd1, 1'b0, 16'h0600);

    // random windows and accesses
    for (int a = 0; a < 8; a++) begin
      for (int f = 0; f < 4; f += 2) begin
        logic [15:0] lo, hi;
        lo = 16'($urandom());
        hi = ($urandom_range(0, 7) == 0) ? lo : lo + 16'($urandom_range(1, 16'h3000));
        cfg_wr(4'd8, 4'(a), 3'(f), lo);
        cfg_wr(4'd8, 4'(a), 3'(f + 1), hi);
      end
    end
    cfg_wr(4'd8, 4'd0, 3'd4, 16'($urandom()));
    cfg_wr(4'd8, 4'd0, 3'd5, m_tlo + 16'h0800);
    for (int n = 0; n < 300; n++) begin
      logic [3:0] id;
      logic [1:0] k;
      id = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(8, 15)) : 4'($urandom_range(0, 7));
      k  = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      if ($urandom_range(0, 19) == 0)
        cfg_wr(4'($urandom_range(0, 7)), 4'($urandom_range(0, 7)), 3'($urandom_range(0, 5)),
               16'($urandom()));
      access("R1 R2 random", id, k, 1'($urandom_range(0, 1)), pick_addr(id));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule